// File: doc/BRIEF.md
# Crate Energy Summer with Timestamped Link Output

This block sits in the centre slot of a detector crate and adds up the energy sums reported by the front-end boards on both sides of the backplane. Every clock it takes one 12-bit energy value from each of eight boards on the left and eight on the right. It adds the sixteen values into a single crate total through a fixed-depth pipelined adder tree, so a new crate total leaves the block on every clock.

The block also keeps a free-running timestamp counter. All crates share a common T0 strobe, and that strobe zeroes the counter on the edge where it is seen. The results go out as a stream of link words with a one-bit word-type flag. Each sum word carries a crate total. Now and then a timestamp word takes the place of one sum word. It carries the time at which the displaced sample was taken, so the receiving processor can line up the streams from several crates. A reduced-width mode sends only eight-bit values. In that mode totals are clamped at full scale, and timestamp words carry the low eight bits of the time.

Top module: `crate_summer`

## Requirements
- R1: In full-width mode, every sum word equals the exact unsigned sum of the 8 left and 8 right 12-bit board values sampled on one clock edge, presented as a 16-bit value (maximum 65520).
- R2: A set of board values sampled on clock edge k appears on `link_word` after edge k+4, and a new word is produced on every clock once the output is valid.
- R3: While `rst` is high, `link_valid`, `link_is_ts` and `link_word` are all 0. After reset is released, the first edge with `rst` low is edge k0. `link_valid` stays 0 through edge k0+3, rises after edge k0+4, and then stays high.
- R4: The timestamp counter adds one on every clock edge. It becomes 0 on any edge where `rst` or `t0_sync` is high.
- R5: A timestamp word carries the counter value that held when its sample was taken. That value is the current count minus the 4-cycle summation latency, and it is sent as the low 16 bits of the timestamp.
- R6: `link_is_ts` is 1 only on timestamp words and only while `link_valid` is 1. The first valid word after reset is a timestamp word. After that, exactly 256 sum words come between consecutive timestamp words.
- R7: When `narrow_mode` is 1 on the edge a word is formed, a sum above 255 is sent as 255, a timestamp word carries the low 8 bits of the time, and bits 15:8 of `link_word` are 0.
- R8: A `t0_sync` pulse changes neither the values of the sum words nor the spacing of timestamp words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crate clock, one sample per edge |
| rst | input | 1 | Synchronous active-high reset |
| t0_sync | input | 1 | Global T0 strobe; zeroes the timestamp counter |
| narrow_mode | input | 1 | 1 selects the eight-bit reduced link format |
| left_sums | input | 96 | Eight 12-bit board sums from the left side; board j in bits 12j+11:12j |
| right_sums | input | 96 | Eight 12-bit board sums from the right side; board j in bits 12j+11:12j |
| link_word | output | 16 | Link payload: crate total or timestamp |
| link_is_ts | output | 1 | 1 when `link_word` holds a timestamp |
| link_valid | output | 1 | 1 once the pipeline carries real samples |

## Verification
Each sum is due four edges after the edge that sampled its board values. The bench drives inputs on a falling edge and reads the matching result on the falling edge after the fifth rising edge. When that slot turns out to be a timestamp word, it reads one cycle later while the inputs are still held. The expected timestamp for each timestamp word is worked out from the bench's own edge count, measured from the last edge with reset or T0 high, minus the four-cycle latency. The spacing of 256 sum words is counted word by word on the falling edges. The latency check switches inputs right after a timestamp word, so both the old and the new value fall in sum slots.

// File: rtl/crate_sum_pkg.sv
package crate_sum_pkg;

    // Default geometry of a crate.
    localparam int unsigned DEF_BOARDS_PER_SIDE = 8;
    localparam int unsigned DEF_BOARD_W         = 12;
    localparam int unsigned DEF_TS_W            = 32;
    localparam int unsigned DEF_SUMS_PER_TS     = 256;
    localparam int unsigned DEF_NARROW_W        = 8;

    // Kind of word placed on the link.
    typedef enum logic {
        WORD_SUM = 1'b0,
        WORD_TS  = 1'b1
    } word_kind_e;

    // Clamp a value to the largest number representable in w bits.
    function automatic logic [31:0] clamp_to_width(input logic [31:0] v,
                                                   input int unsigned w);
        logic [31:0] top;
        top = (32'd1 << w) - 32'd1;
        return (v > top) ? top : v;
    endfunction

endpackage

// File: rtl/cs_adder_tree.sv
module cs_adder_tree #(
    parameter int unsigned N_IN  = 16,
    parameter int unsigned IN_W  = 12,
    parameter int unsigned OUT_W = IN_W + $clog2(N_IN)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_IN*IN_W-1:0]  leaves,
    output logic [OUT_W-1:0]      total
);
    // Heap layout: node i (1..N_IN-1) adds children 2i and 2i+1.
    // Children at index >= N_IN are the input leaves. Slot s of the
    // heap vector holds heap index s+1.
    localparam int unsigned N_NODE = N_IN - 1;

    logic [N_IN*OUT_W-1:0]        leaf_ext;
    logic [N_NODE*OUT_W-1:0]      node_q;
    logic [(N_NODE+N_IN)*OUT_W-1:0] heap;

    always_comb begin
        for (int g = 0; g < N_IN; g++) begin
            leaf_ext[g*OUT_W +: OUT_W] = OUT_W'(leaves[g*IN_W +: IN_W]);
        end
    end

    assign heap = {leaf_ext, node_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            node_q <= '0;
        end else begin
            for (int i = 1; i <= N_NODE; i++) begin
                node_q[(i-1)*OUT_W +: OUT_W] <= heap[(2*i-1)*OUT_W +: OUT_W]
                                              + heap[(2*i)*OUT_W +: OUT_W];
            end
        end
    end

    assign total = node_q[OUT_W-1:0];

endmodule

// File: rtl/cs_timestamp.sv
module cs_timestamp #(
    parameter int unsigned TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            t0_sync,
    output logic [TS_W-1:0] ts
);
    always_ff @(posedge clk) begin
        if (rst || t0_sync) begin
            ts <= '0;
        end else begin
            ts <= ts + TS_W'(1);
        end
    end
endmodule

// File: rtl/cs_link_former.sv
module cs_link_former
    import crate_sum_pkg::*;
#(
    parameter int unsigned SUM_W       = 16,
    parameter int unsigned TS_W        = 32,
    parameter int unsigned NARROW_W    = 8,
    parameter int unsigned SUMS_PER_TS = 256,
    parameter int unsigned LAT         = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             narrow,
    input  logic [SUM_W-1:0] sum_in,
    input  logic [TS_W-1:0]  ts_in,
    output logic [SUM_W-1:0] word,
    output logic             is_ts,
    output logic             valid
);
    localparam int unsigned SLOT_W = $clog2(SUMS_PER_TS + 1);
    localparam int unsigned FILL_W = $clog2(LAT + 1);

    logic [FILL_W-1:0] fill_q;
    logic [SLOT_W-1:0] slot_q;
    word_kind_e        kind_q;
    logic              primed;
    logic [TS_W-1:0]   label;
    logic [SUM_W-1:0]  ts_payload;
    logic [SUM_W-1:0]  sum_payload;

    assign primed = (fill_q == FILL_W'(LAT));
    // Time at which the sample now leaving the tree was taken.
    assign label  = ts_in - TS_W'(LAT);

    always_comb begin
        if (narrow) begin
            ts_payload  = SUM_W'(label[NARROW_W-1:0]);
            sum_payload = SUM_W'(clamp_to_width(32'(sum_in), NARROW_W));
        end else begin
            ts_payload  = label[SUM_W-1:0];
            sum_payload = sum_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            slot_q <= '0;
            kind_q <= WORD_SUM;
            word   <= '0;
            valid  <= 1'b0;
        end else begin
            if (!primed) begin
                fill_q <= fill_q + FILL_W'(1);
            end
            valid <= primed;
            if (primed) begin
                if (slot_q == '0) begin
                    kind_q <= WORD_TS;
                    word   <= ts_payload;
                end else begin
                    kind_q <= WORD_SUM;
                    word   <= sum_payload;
                end
                slot_q <= (slot_q == SLOT_W'(SUMS_PER_TS)) ? '0
                                                           : slot_q + SLOT_W'(1);
            end
        end
    end

    assign is_ts = (kind_q == WORD_TS);

endmodule

// File: rtl/crate_summer.sv
module crate_summer
    import crate_sum_pkg::*;
#(
    parameter int unsigned BOARDS_PER_SIDE = DEF_BOARDS_PER_SIDE,
    parameter int unsigned BOARD_W         = DEF_BOARD_W,
    parameter int unsigned TS_W            = DEF_TS_W,
    parameter int unsigned SUMS_PER_TS     = DEF_SUMS_PER_TS,
    parameter int unsigned NARROW_W        = DEF_NARROW_W,
    localparam int unsigned N_BOARDS       = 2 * BOARDS_PER_SIDE,
    localparam int unsigned TREE_DEPTH     = $clog2(N_BOARDS),
    localparam int unsigned SUM_W          = BOARD_W + TREE_DEPTH,
    localparam int unsigned SIDE_W         = BOARDS_PER_SIDE * BOARD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              t0_sync,
    input  logic              narrow_mode,
    input  logic [SIDE_W-1:0] left_sums,
    input  logic [SIDE_W-1:0] right_sums,
    output logic [SUM_W-1:0]  link_word,
    output logic              link_is_ts,
    output logic              link_valid
);
    logic [SUM_W-1:0] crate_total;
    logic [TS_W-1:0]  ts_now;

    cs_adder_tree #(
        .N_IN  (N_BOARDS),
        .IN_W  (BOARD_W),
        .OUT_W (SUM_W)
    ) u_tree (
        .clk    (clk),
        .rst    (rst),
        .leaves ({right_sums, left_sums}),
        .total  (crate_total)
    );

    cs_timestamp #(
        .TS_W (TS_W)
    ) u_ts (
        .clk     (clk),
        .rst     (rst),
        .t0_sync (t0_sync),
        .ts      (ts_now)
    );

    cs_link_former #(
        .SUM_W       (SUM_W),
        .TS_W        (TS_W),
        .NARROW_W    (NARROW_W),
        .SUMS_PER_TS (SUMS_PER_TS),
        .LAT         (TREE_DEPTH)
    ) u_fmt (
        .clk    (clk),
        .rst    (rst),
        .narrow (narrow_mode),
        .sum_in (crate_total),
        .ts_in  (ts_now),
        .word   (link_word),
        .is_ts  (link_is_ts),
        .valid  (link_valid)
    );

endmodule

// File: rtl/crate_summer_checker.sv
module crate_summer_checker #(
    parameter int unsigned SUM_W       = 16,
    parameter int unsigned TS_W        = 32,
    parameter int unsigned NARROW_W    = 8,
    parameter int unsigned SUMS_PER_TS = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             t0_sync,
    input logic             narrow_mode,
    input logic [TS_W-1:0]  ts_now,
    input logic [SUM_W-1:0] link_word,
    input logic             link_is_ts,
    input logic             link_valid
);
    localparam int unsigned SLOT_W = $clog2(SUMS_PER_TS + 1);

    logic [SLOT_W-1:0] sums_seen;
    logic              ts_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sums_seen <= '0;
            ts_seen   <= 1'b0;
        end else if (link_valid) begin
            if (link_is_ts) begin
                sums_seen <= '0;
                ts_seen   <= 1'b1;
            end else begin
                sums_seen <= sums_seen + SLOT_W'(1);
            end
        end
    end

    assert_ts_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
        link_is_ts |-> link_valid);

    assert_ts_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        (link_valid && link_is_ts && ts_seen) |-> (sums_seen == SLOT_W'(SUMS_PER_TS)));

    assert_sum_run_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (link_valid && !link_is_ts) |-> (ts_seen && sums_seen < SLOT_W'(SUMS_PER_TS)));

    assert_ts_counts_up_R4: assert property (@(posedge clk) disable iff (rst)
        !t0_sync |=> (ts_now == $past(ts_now) + TS_W'(1)));

    assert_sync_zeroes_R4: assert property (@(posedge clk) disable iff (rst)
        t0_sync |=> (ts_now == '0));

    assert_valid_sticks_R3: assert property (@(posedge clk) disable iff (rst)
        link_valid |=> link_valid);

    assert_narrow_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (link_valid && $past(narrow_mode)) |-> ((link_word >> NARROW_W) == '0));

endmodule

bind crate_summer crate_summer_checker #(
    .SUM_W       (SUM_W),
    .TS_W        (TS_W),
    .NARROW_W    (NARROW_W),
    .SUMS_PER_TS (SUMS_PER_TS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .t0_sync     (t0_sync),
    .narrow_mode (narrow_mode),
    .ts_now      (ts_now),
    .link_word   (link_word),
    .link_is_ts  (link_is_ts),
    .link_valid  (link_valid)
);

// File: tb/crate_summer_tb.sv
module crate_summer_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int BPS  = 8;
    localparam int BW   = 12;
    localparam int SW   = 16;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [11:0] lb;
        logic [11:0] rb;
        logic [11:0] step;
        logic        nar;
        logic [15:0] expv;
    } vec_t;

    // Board j on a side = base + j*step. Expected totals worked by hand.
    localparam vec_t VECS [NVEC] = '{
        '{12'd0,    12'd0,    12'd0,  1'b0, 16'd0},      // R1 all zero
        '{12'd4095, 12'd4095, 12'd0,  1'b0, 16'd65520},  // R1 full scale
        '{12'd1,    12'd2,    12'd0,  1'b0, 16'd24},     // R1
        '{12'd100,  12'd0,    12'd10, 1'b0, 16'd1360},   // R1 ramp left+right
        '{12'd7,    12'd300,  12'd3,  1'b0, 16'd2624},   // R1 mixed
        '{12'd10,   12'd5,    12'd0,  1'b1, 16'd120},    // R7 below clamp
        '{12'd15,   12'd16,   12'd0,  1'b1, 16'd248},    // R7 just below
        '{12'd16,   12'd16,   12'd0,  1'b1, 16'd255},    // R7 256 -> 255
        '{12'd4095, 12'd4095, 12'd0,  1'b1, 16'd255},    // R7 max -> 255
        '{12'd0,    12'd0,    12'd0,  1'b1, 16'd0}       // R7 zero
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             t0_sync = 1'b0;
    logic             narrow_mode = 1'b0;
    logic [BPS*BW-1:0] left_sums = '0;
    logic [BPS*BW-1:0] right_sums = '0;
    logic [SW-1:0]    link_word;
    logic             link_is_ts;
    logic             link_valid;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int zero_cyc = 0;
    logic nar_q  = 1'b0;
    int sums_since = 0;
    bit ts_seen_tb = 1'b0;

    crate_summer u_dut (
        .clk         (clk),
        .rst         (rst),
        .t0_sync     (t0_sync),
        .narrow_mode (narrow_mode),
        .left_sums   (left_sums),
        .right_sums  (right_sums),
        .link_word   (link_word),
        .link_is_ts  (link_is_ts),
        .link_valid  (link_valid)
    );

    always #2.5 clk = ~clk;

    // Edge bookkeeping: last edge with rst or T0 high is time zero.
    always @(posedge clk) begin
        cyc   <= cyc + 1;
        nar_q <= narrow_mode;
        if (rst || t0_sync) zero_cyc <= cyc + 1;
    end

    task automatic chk(input string req, input longint act, input longint expv);
        n_checks++;
        if (act != expv) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // Timestamp word content and spacing, checked on every word.
    always @(negedge clk) begin
        if (rst) begin
            sums_since = 0;
            ts_seen_tb = 1'b0;
        end else if (link_valid) begin
            if (link_is_ts) begin
                longint lbl;
                lbl = longint'(cyc - 4 - zero_cyc - 1);
                lbl = nar_q ? (lbl & 64'hFF) : (lbl & 64'hFFFF);
                chk("R5 timestamp word value", longint'(link_word), lbl);
                if (ts_seen_tb) chk("R6/R8 sums between timestamps", sums_since, 256);
                sums_since = 0;
                ts_seen_tb = 1'b1;
            end else begin
                sums_since++;
            end
        end
    end

    task automatic drive(input vec_t v);
        for (int j = 0; j < BPS; j++) begin
            left_sums[j*BW +: BW]  = v.lb + 12'(j) * v.step;
            right_sums[j*BW +: BW] = v.rb + 12'(j) * v.step;
        end
        narrow_mode = v.nar;
    endtask

    task automatic wait_ts();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (link_valid && link_is_ts) return;
        end
        chk("R6 timestamp word seen", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("R2 watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        // Reset state (R3)
        drive(VECS[2]);
        repeat (3) @(negedge clk);
        chk("R3 valid in reset", longint'(link_valid), 0);
        chk("R3 flag in reset", longint'(link_is_ts), 0);
        chk("R3 word in reset", longint'(link_word), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 valid before fill", longint'(link_valid), 0);
        @(negedge clk);
        chk("R3 valid after fill", longint'(link_valid), 1);
        chk("R6 first word is timestamp", longint'(link_is_ts), 1);
        chk("R5 first timestamp is zero", longint'(link_word), 0);
        @(negedge clk);
        chk("R1 first sum word", longint'(link_word), 24);

        // Latency (R2): switch inputs right after a timestamp word.
        wait_ts();
        drive(VECS[3]);
        repeat (4) @(negedge clk);
        chk("R2 old value at edge k+3", longint'(link_word), 24);
        @(negedge clk);
        chk("R2 new value at edge k+4", longint'(link_word), 1360);
        @(negedge clk);
        chk("R2 one word per clock", longint'(link_valid && !link_is_ts), 1);

        // Vector table (R1, R7)
        for (int v = 0; v < NVEC; v++) begin
            drive(VECS[v]);
            repeat (5) @(negedge clk);
            if (link_is_ts) @(negedge clk);
            chk(VECS[v].nar ? "R7 narrow sum" : "R1 crate sum",
                longint'(link_word), longint'(VECS[v].expv));
        end

        // Narrow timestamp word (R7)
        drive(VECS[8]);
        wait_ts();
        chk("R7 narrow timestamp upper bits", longint'(link_word >> 8), 0);

        // T0 sync (R4, R5, R8)
        drive(VECS[4]);
        wait_ts();
        repeat (10) @(negedge clk);
        t0_sync = 1'b1;
        @(negedge clk);
        t0_sync = 1'b0;
        repeat (3) @(negedge clk);
        if (link_is_ts) @(negedge clk);
        chk("R8 sum unchanged across sync", longint'(link_word), 2624);
        wait_ts();
        wait_ts();
        @(negedge clk);
        chk("R8 sum after sync", longint'(link_word), 2624);

        // Mid-run reset returns to the reset state (R3)
        rst = 1'b1;
        @(negedge clk);
        chk("R3 valid cleared by reset", longint'(link_valid), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 timestamp first after reset", longint'(link_is_ts), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule